// File: doc/BRIEF.md
# Skew-Delay Code Register Port

This block is the digital control port of a three-channel skew-compensation delay line. It holds one 6-bit delay code for each colour channel (red, green, blue). An external host writes and reads these codes over a four-wire serial bus made of a serial clock, an active-low select, data in and data out. Every transaction is 16 bits long, sent most significant bit first. The first byte carries the direction and the channel address. The second byte carries the code. The three code outputs drive the delay-line tap selection directly.

The block also decodes three static strap pins into a control-mode indication: powered down, analog control, serial-bus control, or two-wire-bus control. Serial traffic is honoured only while serial-bus control is selected. The codes survive power-down. The bus pins are oversampled in the block clock domain, so the serial clock must run well below the block clock. Six or more block cycles per serial half period is enough.

Top module: `dlyspi_top`

## Requirements
- R1: After reset all three codes are 0, `spi_sdo` is 0 and `spi_sdo_oe` is 0.
- R2: `ctrl_mode` reports the strap decode: 2'b00 when `pwr_en`=0; 2'b01 when `pwr_en`=1 and `mode_analog`=1; 2'b10 when `pwr_en`=1, `mode_analog`=0 and `bus_spi`=1; 2'b11 when `pwr_en`=1, `mode_analog`=0 and `bus_spi`=0.
- R3: A complete write stores bits 5:0 of the second byte into the addressed register. A write has first byte bit 7 = 0, bits 6:2 = 0, and bits 1:0 = address, with 00 red, 01 green and 10 blue. Bits 7:6 of the second byte are ignored, and the other registers stay unchanged.
- R4: A read has first byte bit 7 = 1, bits 6:2 = 0, and bits 1:0 = address. During the second byte, `spi_sdo` presents 2'b00 followed by the addressed 6-bit code, MSB first. No register changes.
- R5: `spi_sdo` changes only after a falling serial-clock edge, so it is stable when the host samples on the rising edge. While select is high, `spi_sdo` is 0 and `spi_sdo_oe` is 0.
- R6: Address 11 is ignored on write, and a read of address 11 returns eight zero bits.
- R7: A first byte with any of bits 6:2 set is ignored: it writes nothing and reads back zeros.
- R8: If select rises before the 16th rising clock edge, no register changes.
- R9: In power-down, analog or two-wire mode, serial traffic changes nothing, and the codes keep their values through power-down.
- R10: Clock edges after the 16th within one select window have no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Strap: 0 = power-down |
| mode_analog | input | 1 | Strap: 1 = analog control |
| bus_spi | input | 1 | Strap: 1 = four-wire bus, 0 = two-wire bus |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low transaction select |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial read data to host |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo` |
| ctrl_mode | output | 2 | Decoded control mode (see R2) |
| dly_red | output | 6 | Red channel delay code |
| dly_grn | output | 6 | Green channel delay code |
| dly_blu | output | 6 | Blue channel delay code |

## Verification
Directed frames cover three cases. The first is the nominal green write and blue read. The second is a write whose upper data bits are set, which separates masking of bits 7:6 from storing all eight bits. The third is made of frames aimed at address 11 and at commands with stray ones, which separate real decoding from looking only at bits 1:0. Frames cut short after 12 bits and frames stretched to 20 bits separate commit-at-bit-16 from commit-at-select-rise and from continued shifting. A random mix of reads, writes, bad commands, short and long frames is checked against a bench register model after each frame. Each strap combination is tried with write traffic, and the codes are read back afterwards to show they were retained.

// File: rtl/dlyspi_pkg.sv
package dlyspi_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_ANALOG = 2'b01,
        MODE_SPI    = 2'b10,
        MODE_I2C    = 2'b11
    } ctrl_mode_e;

    localparam int NUM_CH = 3;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/dlyspi_sync.sv
module dlyspi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dlyspi_mode_dec.sv
module dlyspi_mode_dec
    import dlyspi_pkg::*;
(
    input  logic       pwr_en,
    input  logic       analog_sel,
    input  logic       spi_sel,
    output ctrl_mode_e mode
);
    always_comb begin
        if (!pwr_en)         mode = MODE_OFF;
        else if (analog_sel) mode = MODE_ANALOG;
        else if (spi_sel)    mode = MODE_SPI;
        else                 mode = MODE_I2C;
    end
endmodule

// File: rtl/dlyspi_top.sv
module dlyspi_top
    import dlyspi_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en,
    input  logic              mode_analog,
    input  logic              bus_spi,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_oe,
    output logic [1:0]        ctrl_mode,
    output logic [CODE_W-1:0] dly_red,
    output logic [CODE_W-1:0] dly_grn,
    output logic [CODE_W-1:0] dly_blu
);
    localparam int FRAME_BITS = 2 * BYTE_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int BIT_W      = $clog2(BYTE_W);
    localparam int PIN_W      = 6;

    typedef struct packed {
        logic [CNT_W-1:0]               cnt;
        logic [BYTE_W-1:0]              shreg;
        logic                           rd;
        logic                           cmd_ok;
        logic [1:0]                     addr;
        logic [BYTE_W-1:0]              rdata;
        logic                           sdo;
        logic                           oe;
        logic [1:0]                     mode;
        logic                           sck_prev;
        logic [NUM_CH-1:0][CODE_W-1:0]  regs;
    } state_t;

    state_t st_d, st_q;

    // synchronized pins: {pwr, analog, spi, cs_n, sck, sdi}
    logic [PIN_W-1:0] pins_s;
    logic             pwr_s, analog_s, spisel_s, cs_s, sck_s, sdi_s;
    ctrl_mode_e       mode_nx;

    dlyspi_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(6'b000100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({pwr_en, mode_analog, bus_spi, spi_cs_n, spi_sck, spi_sdi}),
        .q    (pins_s)
    );

    assign {pwr_s, analog_s, spisel_s, cs_s, sck_s, sdi_s} = pins_s;

    dlyspi_mode_dec u_mode (
        .pwr_en    (pwr_s),
        .analog_sel(analog_s),
        .spi_sel   (spisel_s),
        .mode      (mode_nx)
    );

    logic             sck_rise, sck_fall, frame_on, wr_fire;
    logic [1:0]       cur_addr;
    logic [BYTE_W-1:0] cmd_byte;
    logic [BIT_W-1:0] bidx;

    function automatic logic [CODE_W-1:0] pick_reg(
        input logic [NUM_CH-1:0][CODE_W-1:0] r, input logic [1:0] a);
        logic [CODE_W-1:0] v;
        v = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (a == 2'(c)) v = r[c];
        end
        return v;
    endfunction

    always_comb begin
        st_d     = st_q;
        sck_rise = sck_s & ~st_q.sck_prev;
        sck_fall = ~sck_s & st_q.sck_prev;
        frame_on = !cs_s && (st_q.mode == MODE_SPI);
        wr_fire  = 1'b0;
        cmd_byte = {st_q.shreg[BYTE_W-2:0], sdi_s};
        bidx     = BIT_W'(CNT_W'(FRAME_BITS - 1) - st_q.cnt);

        st_d.sck_prev = sck_s;
        st_d.mode     = mode_nx;

        if (!frame_on) begin
            st_d.cnt    = '0;
            st_d.sdo    = 1'b0;
            st_d.oe     = 1'b0;
            st_d.rd     = 1'b0;
            st_d.cmd_ok = 1'b0;
        end else begin
            st_d.oe = 1'b1;
            if (sck_rise && st_q.cnt != CNT_W'(FRAME_BITS)) begin
                st_d.shreg = cmd_byte;
                st_d.cnt   = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(BYTE_W - 1)) begin
                    st_d.rd     = cmd_byte[BYTE_W-1];
                    st_d.addr   = cmd_byte[1:0];
                    st_d.cmd_ok = (cmd_byte[BYTE_W-2:2] == '0) && (cmd_byte[1:0] < 2'(NUM_CH));
                    st_d.rdata  = '0;
                    if (st_d.cmd_ok && cmd_byte[BYTE_W-1]) begin
                        st_d.rdata[CODE_W-1:0] = pick_reg(st_q.regs, cmd_byte[1:0]);
                    end
                end
                if (st_q.cnt == CNT_W'(FRAME_BITS - 1) && !st_q.rd && st_q.cmd_ok) begin
                    wr_fire = 1'b1;
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (st_q.addr == 2'(c)) st_d.regs[c] = cmd_byte[CODE_W-1:0];
                    end
                end
            end
            if (sck_fall) begin
                if (st_q.cnt >= CNT_W'(BYTE_W) && st_q.cnt < CNT_W'(FRAME_BITS)
                    && st_q.rd && st_q.cmd_ok) begin
                    st_d.sdo = st_q.rdata[bidx];
                end else begin
                    st_d.sdo = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr   = st_q.addr;
    assign spi_sdo    = st_q.sdo;
    assign spi_sdo_oe = st_q.oe;
    assign ctrl_mode  = st_q.mode;
    assign dly_red    = st_q.regs[0];
    assign dly_grn    = st_q.regs[1];
    assign dly_blu    = st_q.regs[2];
endmodule

// File: rtl/dlyspi_checks.sv
module dlyspi_checks #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_on,
    input logic              sck_fall,
    input logic              wr_fire,
    input logic [1:0]        cur_addr,
    input logic [1:0]        ctrl_mode,
    input logic              spi_sdo,
    input logic              spi_sdo_oe,
    input logic [CODE_W-1:0] dly_red,
    input logic [CODE_W-1:0] dly_grn,
    input logic [CODE_W-1:0] dly_blu
);
    assert_sdo_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sdo_oe |-> !spi_sdo);

    assert_sdo_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(frame_on) && !$past(sck_fall)) |-> $stable(spi_sdo));

    assert_commit_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_fire) |-> ($stable(dly_red) && $stable(dly_grn) && $stable(dly_blu)));

    assert_no_addr3_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> cur_addr != 2'b11);

    assert_spi_mode_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> ctrl_mode == 2'b10);
endmodule

bind dlyspi_top dlyspi_checks #(.CODE_W(CODE_W)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_on  (frame_on),
    .sck_fall  (sck_fall),
    .wr_fire   (wr_fire),
    .cur_addr  (cur_addr),
    .ctrl_mode (ctrl_mode),
    .spi_sdo   (spi_sdo),
    .spi_sdo_oe(spi_sdo_oe),
    .dly_red   (dly_red),
    .dly_grn   (dly_grn),
    .dly_blu   (dly_blu)
);

// File: tb/dlyspi_top_test.sv
module dlyspi_top_test;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0, mode_analog = 1'b0, bus_spi = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_sdi = 1'b0;
    logic spi_sdo, spi_sdo_oe;
    logic [1:0] ctrl_mode;
    logic [5:0] dly_red, dly_grn, dly_blu;

    int checks = 0;
    int errors = 0;
    logic [5:0] model [3];
    logic spi_active = 1'b0;

    always #5 clk = ~clk;

    dlyspi_top uut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .mode_analog(mode_analog),
        .bus_spi(bus_spi), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_sdi(spi_sdi),
        .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe), .ctrl_mode(ctrl_mode),
        .dly_red(dly_red), .dly_grn(dly_grn), .dly_blu(dly_blu)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        chk(dly_red == model[0], {req, " red"}, 32'(dly_red), 32'(model[0]));
        chk(dly_grn == model[1], {req, " green"}, 32'(dly_grn), 32'(model[1]));
        chk(dly_blu == model[2], {req, " blue"}, 32'(dly_blu), 32'(model[2]));
    endtask

    function automatic logic cmd_valid(input logic [7:0] cmd);
        return (cmd[6:2] == 5'd0) && (cmd[1:0] != 2'b11);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] cmd);
        return cmd_valid(cmd) ? {2'b00, model[cmd[1:0]]} : 8'h00;
    endfunction

    task automatic set_mode(input logic p, input logic a, input logic s);
        pwr_en = p; mode_analog = a; bus_spi = s;
        repeat (8) @(negedge clk);
    endtask

    // one framed transfer; model updated when the frame is complete
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nbits,
                        output logic [7:0] rbyte);
        logic [7:0] expv;
        rbyte = 8'h00;
        expv  = exp_read(cmd);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8)       spi_sdi = cmd[7-i];
            else if (i < 16) spi_sdi = dat[15-i];
            else             spi_sdi = 1'($urandom);
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 16) rbyte[15-i] = spi_sdo;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        if (spi_active && nbits >= 16 && !cmd[7] && cmd_valid(cmd))
            model[cmd[1:0]] = dat[5:0];
        if (spi_active && nbits >= 16 && cmd[7])
            chk(rbyte == expv, "R4 read data", 32'(rbyte), 32'(expv));
        chk(spi_sdo == 1'b0 && spi_sdo_oe == 1'b0, "R5 idle after select high",
            32'({spi_sdo_oe, spi_sdo}), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 3; c++) model[c] = 6'd0;
        repeat (4) @(negedge clk);
        check_regs("R1");
        chk(spi_sdo == 0 && spi_sdo_oe == 0, "R1 sdo reset", 32'({spi_sdo_oe, spi_sdo}), 0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(ctrl_mode == 2'b00, "R2 power-down", 32'(ctrl_mode), 0);

        set_mode(1, 0, 1);
        chk(ctrl_mode == 2'b10, "R2 spi", 32'(ctrl_mode), 2);
        spi_active = 1'b1;

        xfer(8'h01, 8'd42, 16, rb);            // R3 green write
        check_regs("R3");
        xfer(8'h02, 8'd21, 16, rb);
        xfer(8'h82, 8'h00, 16, rb);            // R4 blue read
        chk(rb == 8'd21, "R4 blue 21", 32'(rb), 21);
        check_regs("R4");
        xfer(8'h00, 8'hC5, 16, rb);            // R3 upper data bits ignored
        chk(dly_red == 6'd5, "R3 masked data", 32'(dly_red), 5);

        xfer(8'h03, 8'h3F, 16, rb);            // R6 address 11 write
        check_regs("R6");
        xfer(8'h83, 8'h00, 16, rb);
        chk(rb == 8'h00, "R6 read zero", 32'(rb), 0);

        xfer(8'h41, 8'h11, 16, rb);            // R7 stray command bits
        check_regs("R7");
        xfer(8'hC2, 8'h00, 16, rb);
        chk(rb == 8'h00, "R7 read zero", 32'(rb), 0);

        xfer(8'h00, 8'h2A, 12, rb);            // R8 aborted frame
        check_regs("R8");

        xfer(8'h02, 8'h37, 20, rb);            // R10 extra clocks
        check_regs("R10");

        spi_active = 1'b0;
        set_mode(1, 1, 1);
        chk(ctrl_mode == 2'b01, "R2 analog", 32'(ctrl_mode), 1);
        xfer(8'h00, 8'h3F, 16, rb);
        check_regs("R9 analog");
        set_mode(1, 0, 0);
        chk(ctrl_mode == 2'b11, "R2 two-wire", 32'(ctrl_mode), 3);
        xfer(8'h01, 8'h3F, 16, rb);
        check_regs("R9 two-wire");
        set_mode(0, 0, 1);
        chk(ctrl_mode == 2'b00, "R2 power-down again", 32'(ctrl_mode), 0);
        xfer(8'h02, 8'h3F, 16, rb);
        check_regs("R9 power-down");
        set_mode(1, 0, 1);
        spi_active = 1'b1;
        for (int c = 0; c < 3; c++) begin
            xfer({6'b100000, 2'(c)}, 8'h00, 16, rb);  // R9 retained codes
        end

        for (int t = 0; t < 80; t++) begin
            logic [7:0] cmd, dat;
            int nb, sel;
            cmd = {1'($urandom), 5'd0, 2'($urandom)};
            if (($urandom % 8) == 0) cmd[6:2] = 5'($urandom);
            dat = 8'($urandom);
            sel = $urandom % 8;
            nb  = (sel == 0) ? 1 + int'($urandom % 15) :
                  (sel == 1) ? 17 + int'($urandom % 8) : 16;
            xfer(cmd, dat, nb, rb);
            check_regs("R3 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule